// File: doc/BRIEF.md
# Three-Level Descriptor Table Walker

This block turns a 32-bit logical address into a physical address by walking descriptor tables held in memory. One request is accepted at a time. The request carries a logical address and a supervisor flag, and it is sampled together with a 32-bit translation control word and two 64-bit root pointers, one for the CPU and one for the supervisor. Descriptors are fetched one 32-bit word at a time over a simple read port. The walk ends in one of two ways: a single-cycle `xl_done` pulse with the physical address, or a single-cycle `xl_fault` pulse.

The control word sets the shape of the walk at run time:

| Field | Meaning |
|---|---|
| bit 31 | translation enable |
| bit 25 | permits the supervisor root |
| bits 19:16 | initial shift, the number of top address bits to ignore |
| bits 15:12 | index width of level A |
| bits 11:8 | index width of level B |
| bits 7:4 | index width of level C |

Each root pointer holds a limit word in bits 63:32 and a table address in bits 31:0. Each level's table uses either 4-byte or 8-byte descriptors. The type code of the descriptor that points into a level selects that size. Any level may end the walk early with a page descriptor.

The controller has six states.

| State | Role |
|---|---|
| IDLE | waits for a request; `req_ready` is high only here |
| FETCH_A, FETCH_B, FETCH_C | read the descriptor word or words of one level |
| DONE | drives `xl_done` for one cycle, then returns to IDLE |
| FAULT | drives `xl_fault` for one cycle, then returns to IDLE |

Transitions:
- IDLE to DONE: a request arrives with translation disabled.
- IDLE to FAULT: the root type is 0 or 1.
- IDLE to FETCH_A: the root type is 2 or 3.
- FETCH_A to FETCH_B and FETCH_B to FETCH_C: a pointer descriptor (type 2 or 3) is read.
- Any FETCH state to DONE: a page descriptor (type 1) is read.
- Any FETCH state to FAULT: an invalid descriptor (type 0) is read, or FETCH_C reads a pointer descriptor.
- DONE to IDLE and FAULT to IDLE: always, after one cycle.

Top module: `pgw_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `xl_done`, `xl_fault` and `mem_valid` are 0.
- R2: With control bit 31 clear, `xl_done` rises in the cycle after the request is accepted, `xl_paddr` equals the logical address, and no read is issued.
- R3: The supervisor root is used when control bit 25 and `req_super` are both 1. Otherwise the CPU root is used.
- R4: The index of a level is taken from the logical address shifted left by the initial shift plus the widths of all earlier levels, then shifted right by 32 minus this level's width. The descriptor address is the table base plus the index times 4 or times 8. Every descriptor address is word aligned.
- R5: The root type occupies limit-word bits 1:0, and an incoming descriptor type does the same for the level it points to. Type 2 selects 4-byte descriptors and type 3 selects 8-byte descriptors. An 8-byte descriptor takes two reads: the type comes from the first word, and the pointer or page value comes from the second word at address +4.
- R6: A pointer descriptor (type 2 or 3) gives the next table base, which is its pointer with bits 3:0 cleared. The root table base is the root address with bits 1:0 cleared.
- R7: A page descriptor (type 1) ends the walk. The physical address is the logical address with all consumed top bits cleared, plus the descriptor value with bits 7:0 cleared.
- R8: The walk ends in a fault, with no translation, in three cases: a root type of 0 or 1, a type-0 descriptor at any level, or a pointer descriptor read at level C.
- R9: Only one request is handled at a time. `req_ready` is low from acceptance until the result pulse. `xl_done` and `xl_fault` never occur together, each lasts one cycle, and `req_ready` returns in the next cycle.
- R10: Shift amounts are taken modulo 32, and a level whose index width is 0 uses index 0.
- R11: While `mem_valid` is high and `mem_ready` is low, the request and its address stay unchanged. A word is taken in the cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | translation request |
| req_ready | output | 1 | walker idle, so a request is accepted |
| req_laddr | input | 32 | logical address |
| req_super | input | 1 | supervisor access |
| ctl_word | input | 32 | translation control word, sampled at acceptance |
| root_cpu | input | 64 | CPU root pointer (limit word in bits 63:32, address in bits 31:0) |
| root_sup | input | 64 | supervisor root pointer, same layout as `root_cpu` |
| mem_valid | output | 1 | descriptor read request |
| mem_addr | output | 32 | descriptor word address |
| mem_ready | input | 1 | read accepted, data valid in the same cycle |
| mem_rdata | input | 32 | descriptor word |
| xl_done | output | 1 | translation finished, one-cycle pulse |
| xl_fault | output | 1 | walk faulted, one-cycle pulse |
| xl_paddr | output | 32 | physical address, valid with `xl_done` |

## Verification
Most wrong internal state in this walker shows up at the ports on the very next read. A wrong shift accumulator, table base or width register puts a different `mem_addr` on the bus. A broken second-word flag for 8-byte descriptors changes the number of reads a walk takes. A lost type code turns a translation into a fault, or a fault into a translation, at the end of the same walk. All of these show within the few cycles of a single translation. Comparing each walk's result, fault flag and read count against an arithmetic model therefore catches them, over a sweep of index values, level widths and descriptor sizes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int CTL_EN_BIT  = 31;
    localparam int CTL_SUP_BIT = 25;
    localparam int CTL_IS_LSB  = 16;
    localparam int CTL_LVA_LSB = 12;
    localparam int CTL_LVB_LSB = 8;
    localparam int CTL_LVC_LSB = 4;
    localparam int LEVELS      = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_A, ST_FETCH_B, ST_FETCH_C, ST_DONE, ST_FAULT
    } walk_state_t;

    localparam logic [1:0] DT_INVALID = 2'd0;
    localparam logic [1:0] DT_PAGE    = 2'd1;
    localparam logic [1:0] DT_SHORT   = 2'd2;
    localparam logic [1:0] DT_LONG    = 2'd3;
endpackage

// File: rtl/pgw_root_sel.sv
module pgw_root_sel #(
    parameter int ADDR_W = 32
) (
    input  logic                  use_sup,
    input  logic [2*ADDR_W-1:0]   root_cpu,
    input  logic [2*ADDR_W-1:0]   root_sup,
    output logic [ADDR_W-1:0]     tbl_base,
    output logic [1:0]            root_type
);
    logic [2*ADDR_W-1:0] pick;
    logic                unused_lim;

    always_comb begin
        pick      = use_sup ? root_sup : root_cpu;
        root_type = pick[ADDR_W+1:ADDR_W];
        tbl_base  = pick[ADDR_W-1:0] & ~ADDR_W'(3);
    end

    assign unused_lim = ^pick[2*ADDR_W-1:ADDR_W+2];
endmodule

// File: rtl/pgw_slice.sv
module pgw_slice #(
    parameter int ADDR_W = 32,
    parameter int FLD_W  = 4,
    localparam int SH_W  = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] laddr,
    input  logic [SH_W-1:0]   pre_sh,
    input  logic [FLD_W-1:0]  width,
    output logic [ADDR_W-1:0] index,
    output logic [ADDR_W-1:0] offset,
    output logic [SH_W-1:0]   post_sh
);
    logic [ADDR_W-1:0] shifted;
    logic [SH_W-1:0]   rsh;

    always_comb begin
        shifted = laddr << pre_sh;
        rsh     = SH_W'(ADDR_W - int'(width));
        index   = (width == '0) ? '0 : (shifted >> rsh);
        post_sh = pre_sh + SH_W'(width);
        offset  = (laddr << post_sh) >> post_sh;
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FLD_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_laddr,
    input  logic                req_super,
    input  logic [31:0]         ctl_word,
    input  logic [2*ADDR_W-1:0] root_cpu,
    input  logic [2*ADDR_W-1:0] root_sup,
    output logic                mem_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ready,
    input  logic [ADDR_W-1:0]   mem_rdata,
    output logic                xl_done,
    output logic                xl_fault,
    output logic [ADDR_W-1:0]   xl_paddr
);
    localparam int SH_W = $clog2(ADDR_W);

    walk_state_t       state_q;
    logic [ADDR_W-1:0] laddr_q, base_q, paddr_q;
    logic              long_q, half_q;
    logic [1:0]        ftype_q;
    logic [SH_W-1:0]   pre_q;
    logic [FLD_W-1:0]  wid_q [LEVELS];

    logic [ADDR_W-1:0] root_base;
    logic [1:0]        root_type;
    logic [FLD_W-1:0]  cur_w;
    logic [ADDR_W-1:0] idx, off;
    logic [SH_W-1:0]   post_sh;
    logic [ADDR_W-1:0] desc_addr;
    logic [1:0]        dtype;
    logic              fetching, fire;
    logic              unused_ctl;

    assign unused_ctl = ^{ctl_word[30:26], ctl_word[24:20], ctl_word[3:0]};

    pgw_root_sel #(.ADDR_W(ADDR_W)) u_root (
        .use_sup  (ctl_word[CTL_SUP_BIT] && req_super),
        .root_cpu (root_cpu),
        .root_sup (root_sup),
        .tbl_base (root_base),
        .root_type(root_type)
    );

    always_comb begin
        unique case (state_q)
            ST_FETCH_A: cur_w = wid_q[0];
            ST_FETCH_B: cur_w = wid_q[1];
            ST_FETCH_C: cur_w = wid_q[2];
            default:    cur_w = '0;
        endcase
    end

    pgw_slice #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_slice (
        .laddr  (laddr_q),
        .pre_sh (pre_q),
        .width  (cur_w),
        .index  (idx),
        .offset (off),
        .post_sh(post_sh)
    );

    assign fetching  = (state_q == ST_FETCH_A) || (state_q == ST_FETCH_B) ||
                       (state_q == ST_FETCH_C);
    assign fire      = fetching && mem_ready;
    assign desc_addr = base_q + (long_q ? (idx << 3) : (idx << 2))
                     + (half_q ? ADDR_W'(4) : '0);
    assign dtype     = long_q ? ftype_q : mem_rdata[1:0];

    // state register and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            laddr_q <= '0;
            base_q  <= '0;
            paddr_q <= '0;
            long_q  <= 1'b0;
            half_q  <= 1'b0;
            ftype_q <= DT_INVALID;
            pre_q   <= '0;
            for (int i = 0; i < LEVELS; i++) wid_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    laddr_q <= req_laddr;
                    half_q  <= 1'b0;
                    if (!ctl_word[CTL_EN_BIT]) begin
                        paddr_q <= req_laddr;
                        state_q <= ST_DONE;
                    end else if (!root_type[1]) begin
                        state_q <= ST_FAULT;
                    end else begin
                        base_q   <= root_base;
                        long_q   <= (root_type == DT_LONG);
                        pre_q    <= SH_W'(ctl_word[CTL_IS_LSB +: FLD_W]);
                        wid_q[0] <= ctl_word[CTL_LVA_LSB +: FLD_W];
                        wid_q[1] <= ctl_word[CTL_LVB_LSB +: FLD_W];
                        wid_q[2] <= ctl_word[CTL_LVC_LSB +: FLD_W];
                        state_q  <= ST_FETCH_A;
                    end
                end
                ST_FETCH_A, ST_FETCH_B, ST_FETCH_C: if (fire) begin
                    if (long_q && !half_q) begin
                        ftype_q <= mem_rdata[1:0];
                        half_q  <= 1'b1;
                    end else begin
                        half_q <= 1'b0;
                        if (dtype == DT_INVALID) begin
                            state_q <= ST_FAULT;
                        end else if (dtype == DT_PAGE) begin
                            paddr_q <= off + (mem_rdata & ~ADDR_W'('hFF));
                            state_q <= ST_DONE;
                        end else if (state_q == ST_FETCH_C) begin
                            state_q <= ST_FAULT;
                        end else begin
                            base_q  <= mem_rdata & ~ADDR_W'('hF);
                            long_q  <= (dtype == DT_LONG);
                            pre_q   <= post_sh;
                            state_q <= (state_q == ST_FETCH_A) ? ST_FETCH_B : ST_FETCH_C;
                        end
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_FAULT: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_valid = fetching;
        mem_addr  = desc_addr;
        xl_done   = (state_q == ST_DONE);
        xl_fault  = (state_q == ST_FAULT);
        xl_paddr  = paddr_q;
    end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   req_laddr,
    input logic                req_super,
    input logic [31:0]         ctl_word,
    input logic [2*ADDR_W-1:0] root_cpu,
    input logic [2*ADDR_W-1:0] root_sup,
    input logic                mem_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ready,
    input logic                xl_done,
    input logic                xl_fault,
    input logic [ADDR_W-1:0]   xl_paddr
);
    logic [1:0] sel_type;
    assign sel_type = (ctl_word[25] && req_super) ? root_sup[ADDR_W+1:ADDR_W]
                                                  : root_cpu[ADDR_W+1:ADDR_W];

    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !ctl_word[31]) |=> (xl_done && xl_paddr == $past(req_laddr))); // R2
    AST_ROOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ctl_word[31] && !sel_type[1]) |=> xl_fault); // R8
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00)); // R4
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready); // R9
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_done && xl_fault)); // R9
    AST_RESULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done || xl_fault) |=> (req_ready && !xl_done && !xl_fault)); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R11
endmodule

bind pgw_walker pgw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_super(req_super), .ctl_word(ctl_word),
    .root_cpu(root_cpu), .root_sup(root_sup), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .xl_done(xl_done),
    .xl_fault(xl_fault), .xl_paddr(xl_paddr)
);

// File: tb/pgw_walker_tb.sv
`timescale 1ns/1ps
module pgw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_super;
    logic [31:0] req_laddr, ctl;
    logic [63:0] rcpu, rsup;
    logic        mem_valid, mem_ready, req_ready, xl_done, xl_fault;
    logic [31:0] mem_addr, mem_rdata, xl_paddr;
    logic [31:0] mem [1024];
    logic        stall_en;
    int unsigned tick = 0;
    int          rd_cnt = 0;
    int          errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    pgw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .req_super(req_super), .ctl_word(ctl),
        .root_cpu(rcpu), .root_sup(rsup), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .xl_done(xl_done), .xl_fault(xl_fault), .xl_paddr(xl_paddr)
    );

    assign mem_rdata = mem[mem_addr[11:2]];
    assign mem_ready = !stall_en || tick[0];

    always @(posedge clk) begin
        tick++;
        if (mem_valid && mem_ready) rd_cnt++;
        if (tick == 190000) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish act=%0d exp=<190000", tick);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    // arithmetic model of the walk
    function automatic void ref_walk(input logic [31:0] la, input logic sup,
                                     output logic f, output logic [31:0] pa, output int nrd);
        logic [63:0] rt;
        logic [31:0] base, w1, ptr, idx;
        logic [1:0]  ty;
        logic        lng;
        int          pre, w, s;
        f = 1'b0; pa = la; nrd = 0;
        if (!ctl[31]) return;
        rt = (ctl[25] && sup) ? rsup : rcpu;
        if (rt[33:32] < 2) begin f = 1'b1; return; end
        base = rt[31:0] & ~32'h3;
        lng  = (rt[33:32] == 2'd3);
        pre  = int'(ctl[19:16]);
        for (int lv = 0; lv < 3; lv++) begin
            w   = int'(ctl[15-4*lv -: 4]);
            idx = (w == 0) ? 32'd0 : ((la << (pre % 32)) >> (32 - w));
            if (lng) begin
                w1 = rdw(base + idx * 8);
                ptr = rdw(base + idx * 8 + 4);
                ty = w1[1:0]; nrd += 2;
            end else begin
                ptr = rdw(base + idx * 4);
                ty = ptr[1:0]; nrd += 1;
            end
            pre += w;
            if (ty == 2'd0) begin f = 1'b1; return; end
            if (ty == 2'd1) begin
                s  = pre % 32;
                pa = ((la << s) >> s) + (ptr & ~32'hFF);
                return;
            end
            if (lv == 2) begin f = 1'b1; return; end
            base = ptr & ~32'hF;
            lng  = (ty == 2'd3);
        end
    endfunction

    task automatic translate(input logic [31:0] la, input logic sup);
        logic        ef;
        logic [31:0] ep;
        int          er, lat;
        bit          busy_ok;
        ref_walk(la, sup, ef, ep, er);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_laddr = la; req_super = sup; rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy_ok = 1;
        while (!xl_done && !xl_fault && lat < 200) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            lat++;
        end
        if (xl_done && xl_fault) busy_ok = 0;
        chk(xl_fault == ef, "R3 R4 R6 R8 fault flag", 64'(xl_fault), 64'(ef));
        if (!ef) chk(xl_done && xl_paddr == ep, "R3 R4 R6 R7 R10 paddr", 64'(xl_paddr), 64'(ep));
        chk(rd_cnt == er, "R5 R11 read count", 64'(rd_cnt), 64'(er));
        chk(busy_ok && !req_ready, "R9 busy/result", 64'(req_ready), 64'(0));
        if (!ctl[31]) chk(lat == 1, "R2 bypass latency", 64'(lat), 64'(1));
    endtask

    initial begin
        logic [31:0] cfg [10];
        cfg[0] = 32'h020F_2220; // R2 translation off
        cfg[1] = 32'h800F_2220;
        cfg[2] = 32'h820F_2220; // R3 supervisor root allowed
        cfg[3] = 32'h800C_3300; // R10 level C width 0
        cfg[4] = 32'h820A_4440;
        cfg[5] = 32'h8000_F000;
        cfg[6] = 32'h820F_F0F0; // R10 widths wrap past 32
        cfg[7] = 32'h820F_2220; // R11 stalled memory
        cfg[8] = 32'h800F_2220; // R8 root type 0
        cfg[9] = 32'h800F_2220; // R8 root type 1
        req_valid = 0; req_laddr = 0; req_super = 0; stall_en = 0;
        ctl = 0; rcpu = 0; rsup = 0;
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        rst_n = 0;
        repeat (4) @(negedge clk);
        chk(req_ready && !xl_done && !xl_fault && !mem_valid, "R1 reset state",
            64'({req_ready, xl_done, xl_fault, mem_valid}), 64'(4'b1000));
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !mem_valid, "R1 after release", 64'({req_ready, mem_valid}), 64'(2'b10));
        for (int c = 0; c < 10; c++) begin
            int tot, sh, n;
            for (int i = 0; i < 1024; i++) mem[i] = $urandom;
            ctl = cfg[c];
            stall_en = (c == 7);
            rcpu = {$urandom, $urandom};
            rsup = {$urandom, $urandom};
            rcpu[33:32] = (c == 8) ? 2'd0 : (c == 9) ? 2'd1 : 2'(2 + (c % 2));
            rsup[33:32] = 2'(3 - (c % 2));
            tot = int'(ctl[19:16]) + int'(ctl[15:12]) + int'(ctl[11:8]) + int'(ctl[7:4]);
            sh  = (tot < 32) ? 32 - tot : 0;
            n   = (c >= 8) ? 16 : 256;
            for (int k = 0; k < n; k++) begin
                logic [31:0] la;
                la = $urandom;
                la = la ^ (32'(k) << sh);
                translate(la, 1'($urandom));
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule